// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block decides when a processor core takes an interrupt and which source it takes. Each source has a pending bit that a one-cycle request pulse sets, and a 3-bit priority level that software configures. The controller holds the processor's current priority level and a global disable flag. A pending source is taken only when its level is strictly above the current level and interrupts are enabled.

When a source is taken, the controller does four things in one clock edge. It saves the current status (disable flag and level) on a small hardware stack. It raises the level to the taken source's level and sets the disable flag. It clears that source's pending bit. It pulses an accept output together with the source index.

A return strobe pops the saved status, which lowers the level again. Requests that were held back are then re-examined. A handler permits nesting by clearing the disable flag through the software write port. A higher-level source can then preempt it.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, dis_o is 1, ipl_o is 0, ack_o is 0, ovf_o and unf_o are 0, and no source is pending.
- R2: A pending source whose level is strictly above ipl_o is accepted while dis_o is 0. A request pulse sampled at clock edge k gives ack_o high for exactly one cycle after edge k+1, with vec_o holding the source index. vec_o keeps that index until the next acceptance.
- R3: In the cycle ack_o is high, dis_o reads 1 and ipl_o reads the accepted source's level. The accepted source's pending bit is cleared, so it is not accepted again without a new request pulse.
- R4: A source whose priority field (bits 3*i+2..3*i of prio_i) is 0 is never accepted.
- R5: When several qualifying sources share the highest level, the source with the lowest index is accepted.
- R6: A request refused because its level is not above ipl_o stays pending. It is accepted once a return lowers ipl_o below its level.
- R7: While dis_o is 1 nothing is accepted. A cycle with dis_wr_en high loads dis_wr_val into dis_o, unless an acceptance or a return happens in the same cycle; those take precedence. After the handler clears dis_o, a source of higher level preempts it.
- R8: A ret_i strobe restores the dis_o and ipl_o values saved at the matching acceptance. No acceptance happens in a cycle with ret_i high.
- R9: The status stack holds STACK_DEPTH entries (default 8). An acceptance while the stack is full sets the sticky ovf_o and saves nothing. A ret_i while the stack is empty sets the sticky unf_o and leaves dis_o and ipl_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Request pulses, one bit per source, set the pending bits |
| prio_i | input | 3*NUM_SRC | Packed 3-bit level per source, source i at bits 3*i+2..3*i |
| dis_wr_en | input | 1 | Software write strobe for the disable flag |
| dis_wr_val | input | 1 | Value written to the disable flag |
| ret_i | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | One-cycle accept pulse |
| vec_o | output | SRC_W | Index of the last accepted source |
| ipl_o | output | 3 | Current processor priority level |
| dis_o | output | 1 | Interrupt disable flag |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
A wrong pending bit or level register shows at the ports as an accept pulse that should not come, or one that comes late or never. This is visible within two clocks of the stimulus, and the scoreboard flags any accept it did not predict. A corrupted stack entry stays hidden until the matching return. It then shows at once as the wrong ipl_o or dis_o, and often as a held request being accepted at the wrong time. The bench therefore checks state after every return, and it drives nesting past the stack depth.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef struct packed {
    logic dis;
    lvl_t ipl;
  } nic_status_t;
endpackage

// File: rtl/nic_pend_bank.sv
module nic_pend_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  // A new request arriving in the clear cycle survives.
  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= (pend_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  lvl_t               prio_i [NUM_SRC],
  input  lvl_t               ipl_i,
  output logic               hit_o,
  output logic [SRC_W-1:0]   idx_o,
  output lvl_t               lvl_o
);
  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && (prio_i[i] > ipl_i) && (prio_i[i] >= lvl_o)) begin
        hit_o = 1'b1;
        idx_o = SRC_W'(i);
        lvl_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/nic_stack.sv
module nic_stack
  import nic_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push_i,
  input  nic_status_t push_data_i,
  input  logic        pop_i,
  output nic_status_t top_o,
  output logic        empty_o,
  output logic        full_o
);
  nic_status_t       mem [DEPTH];
  logic [CW-1:0]     cnt;
  logic [AW-1:0]     rd_idx;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign rd_idx  = AW'(cnt - 1'b1);
  assign top_o   = mem[rd_idx];

  // Storage without reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem[AW'(cnt)] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (push_i && !pop_i && !full_o) cnt <= cnt + 1'b1;
    else if (pop_i && !push_i && !empty_o) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STACK_DEPTH = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  input  logic                     dis_wr_en,
  input  logic                     dis_wr_val,
  input  logic                     ret_i,
  output logic                     ack_o,
  output logic [SRC_W-1:0]         vec_o,
  output logic [LVL_W-1:0]         ipl_o,
  output logic                     dis_o,
  output logic                     ovf_o,
  output logic                     unf_o
);
  lvl_t               prio_arr [NUM_SRC];
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr_mask;
  logic               hit;
  logic [SRC_W-1:0]   win_idx;
  lvl_t               win_lvl;
  logic               grant;
  nic_status_t        cur_st;
  nic_status_t        top_st;
  logic               stk_empty;
  logic               stk_full;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign prio_arr[g] = prio_i[g*LVL_W +: LVL_W];
    assign clr_mask[g] = grant && (win_idx == SRC_W'(g));
  end

  assign cur_st = '{dis: dis_o, ipl: ipl_o};
  assign grant  = hit && !dis_o && !ret_i;

  nic_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .set_i(req_i), .clr_i(clr_mask), .pend_o(pend)
  );

  nic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend_i(pend), .prio_i(prio_arr), .ipl_i(ipl_o),
    .hit_o(hit), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  nic_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst(rst),
    .push_i(grant), .push_data_i(cur_st),
    .pop_i(ret_i), .top_o(top_st),
    .empty_o(stk_empty), .full_o(stk_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o <= 1'b0;
      vec_o <= '0;
      ipl_o <= '0;
      dis_o <= 1'b1;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ack_o <= grant;
      if (grant) vec_o <= win_idx;
      if (ret_i) begin
        if (stk_empty) unf_o <= 1'b1;
        else begin
          dis_o <= top_st.dis;
          ipl_o <= top_st.ipl;
        end
      end else if (grant) begin
        dis_o <= 1'b1;
        ipl_o <= win_lvl;
        if (stk_full) ovf_o <= 1'b1;
      end else if (dis_wr_en) begin
        dis_o <= dis_wr_val;
      end
    end
  end
endmodule

// File: rtl/nic_checker.sv
module nic_checker
  import nic_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ret_i,
  input logic       ack_o,
  input logic [LVL_W-1:0] ipl_o,
  input logic       dis_o,
  input logic       ovf_o,
  input logic       unf_o
);
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);
  assert_accept_masks_R3: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> dis_o);
  assert_level_rises_R3: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (ipl_o > $past(ipl_o)));
  assert_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !$past(dis_o));
  assert_no_accept_on_ret_R8: assert property (@(posedge clk) disable iff (rst)
    ret_i |=> !ack_o);
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    unf_o |=> unf_o);
endmodule

bind nested_irq_ctrl nic_checker u_chk (
  .clk(clk), .rst(rst), .ret_i(ret_i), .ack_o(ack_o), .ipl_o(ipl_o),
  .dis_o(dis_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/nested_irq_ctrl_tb.sv
module nested_irq_ctrl_tb;
  localparam int N = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   req = '0;
  logic [N*3-1:0] prio = '0;
  logic dis_wr_en = 1'b0, dis_wr_val = 1'b0, ret = 1'b0;
  logic ack, dis, ovf, unf;
  logic [2:0] vec, ipl;

  int n_chk = 0, n_fail = 0, n_ack = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  nested_irq_ctrl #(.NUM_SRC(N), .STACK_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .prio_i(prio),
    .dis_wr_en(dis_wr_en), .dis_wr_val(dis_wr_val), .ret_i(ret),
    .ack_o(ack), .vec_o(vec), .ipl_o(ipl), .dis_o(dis),
    .ovf_o(ovf), .unf_o(unf)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Scoreboard entry: source index * 8 + level.
  task automatic expect_accept(input int src, input int lvl);
    exp_q.push_back(src * 8 + lvl);
  endtask

  always @(negedge clk) begin
    if (!rst && ack) begin
      n_ack++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected accept vec", int'(vec), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(vec) == e / 8, "R2/R5 accepted index", int'(vec), e / 8);
        check(int'(ipl) == e % 8, "R3 level on accept", int'(ipl), e % 8);
        check(dis == 1'b1, "R3 disable set on accept", int'(dis), 1);
      end
    end
  end

  task automatic drain(input string tag);
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) begin
      @(negedge clk); #1;
    end
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  task automatic sw_dis(input logic v);
    @(negedge clk); dis_wr_en = 1'b1; dis_wr_val = v;
    @(negedge clk); dis_wr_en = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
  endtask

  function automatic void set_prio(input int s, input int l);
    prio[s*3 +: 3] = 3'(l);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    int srcs[5];
    set_prio(0, 3); set_prio(1, 5); set_prio(2, 5); set_prio(3, 0);
    set_prio(4, 7); set_prio(5, 2); set_prio(6, 2); set_prio(7, 2);
    idle(3);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(dis == 1'b1, "R1 disable after reset", int'(dis), 1);
    check(ipl == 3'd0, "R1 level after reset", int'(ipl), 0);
    check(ack == 1'b0, "R1 accept after reset", int'(ack), 0);
    check(ovf == 1'b0 && unf == 1'b0, "R1 error flags after reset", int'({ovf, unf}), 0);

    sw_dis(1'b0);
    check(dis == 1'b0, "R7 software clear of disable", int'(dis), 1'b0);
    idle(3);
    check(n_ack == 0, "R1 nothing pending after reset", n_ack, 0);

    // R4 level-0 source never accepted
    base = n_ack;
    pulse_req(N'(1) << 3);
    idle(5);
    check(n_ack == base, "R4 level-0 source accepted", n_ack, base);

    // R5 tie at level 5: source 1 wins over source 2
    expect_accept(1, 5);
    pulse_req((N'(1) << 1) | (N'(1) << 2));
    drain("R5 tie accept missing");
    check(ipl == 3'd5, "R3 level raised", int'(ipl), 5);

    // R7 higher source blocked while disabled
    base = n_ack;
    pulse_req(N'(1) << 4);
    idle(5);
    check(n_ack == base, "R7 accepted while disabled", n_ack, base);

    // R7 nesting after software clear; source 2 (level 5) stays held (R6)
    expect_accept(4, 7);
    sw_dis(1'b0);
    drain("R7 preempting accept missing");
    check(ipl == 3'd7, "R3 nested level", int'(ipl), 7);

    // R8 return to the outer handler
    do_ret();
    check(ipl == 3'd5, "R8 level restored", int'(ipl), 5);
    check(dis == 1'b0, "R8 disable restored", int'(dis), 0);
    base = n_ack;
    idle(5);
    check(n_ack == base, "R6 equal level accepted", n_ack, base);

    // R6 held source 2 accepted once level drops to 0
    expect_accept(2, 5);
    do_ret();
    drain("R6 held request not accepted");
    do_ret();
    check(ipl == 3'd0 && dis == 1'b0, "R8 base status restored", int'({dis, ipl}), 0);

    // R9 underflow
    check(unf == 1'b0, "R9 underflow early", int'(unf), 0);
    do_ret();
    check(unf == 1'b1, "R9 underflow flag", int'(unf), 1);
    check(ipl == 3'd0 && dis == 1'b0, "R9 state kept on underflow", int'({dis, ipl}), 0);

    // R9 overflow with a stack of DEPTH entries
    srcs = '{4, 5, 6, 7, 0};
    for (int k = 0; k < 5; k++) set_prio(srcs[k], k + 1);
    for (int k = 0; k < 5; k++) begin
      expect_accept(srcs[k], k + 1);
      pulse_req(N'(1) << srcs[k]);
      drain("R7 nested chain accept missing");
      if (k == DEPTH - 1) check(ovf == 1'b0, "R9 overflow early", int'(ovf), 0);
      if (k < 4) sw_dis(1'b0);
    end
    check(ovf == 1'b1, "R9 overflow flag", int'(ovf), 1);
    do_ret();
    check(ipl == 3'd3 && dis == 1'b0, "R9 top entry after overflow", int'({dis, ipl}), 3);
    check(vec == 3'd0, "R2 vec holds last index", int'(vec), 0);
    idle(3);
    check(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
    finish_run();
  end
endmodule